// File: doc/BRIEF.md
# MDIO Management Master

This block is a serial management master for an Ethernet PHY. It runs one read or one write cycle at a time over an MDC clock line and a bidirectional MDIO data line, in the standard two-bit-opcode frame format. Software works it through two registers. The control register holds the target PHY address, the target register address, a clock-range code, a direction flag and a busy flag. The data register holds the 16-bit word to send, or receives the word read back.

Software loads the data register for a write. It then writes the control register with the busy bit set, which starts the frame. Software polls until the hardware clears busy. No acknowledgement comes back from the PHY, so every transaction ends on a fixed schedule: 64 MDC periods. The MDC rate is the system clock divided by an even divisor that the clock-range code selects. Codes 8 to 15 give small divisors for PHYs that accept fast management clocks.

The register interface is a plain write-strobe and read-data pair, with no back-pressure. The MDIO line leaves the block as a value and an output-enable, for an external tri-state pad.

Top module: `mdio_master`

## Requirements
- R1: After reset, both registers read as zero, MDC is low and the MDIO output-enable is low.
- R2: The control register reads back with the busy flag in bit 0, the direction flag in bit 1 (1 = write, 0 = read), the clock-range code in bits 5:2, the register address in bits 10:6 and the PHY address in bits 15:11.
- R3: A write sends 64 bits, most significant first, with MDIO driven throughout. The bits are 32 ones, start bits 01, opcode 01, the PHY address, the register address, turnaround 10 and the 16 data bits.
- R4: A read sends 32 ones, start bits 01, opcode 10, the PHY address and the register address. It then releases the output-enable for the 2 turnaround bits and the 16 data bits. It samples MDIO on each of the last 16 MDC rising edges, MSB first. The sampled word is in the data register when busy clears.
- R5: Busy stays high for exactly 64 x D clock cycles, where D depends on the clock-range code. Codes 0 to 5 give D = 42, 62, 16, 26, 102 and 124. Codes 8 to 15 give D = 4, 6, 8, 10, 12, 14, 16 and 18.
- R6: The reserved clock-range codes 6 and 7 behave as divide-by-42.
- R7: A transaction finishes on the same schedule with no PHY present. With MDIO pulled high, a read then returns 0xFFFF.
- R8: A control register write is ignored while busy reads 1. This includes the cycle in which the hardware clears busy. The first write after that is accepted.
- R9: MDIO changes only when MDC falls. MDC is low and the output-enable is low whenever busy is clear.
- R10: A write transaction leaves the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 16 | Control register write value |
| data_we | input | 1 | Write strobe for the data register |
| data_wdata | input | 16 | Data register write value |
| ctrl_rdata | output | 16 | Control register contents |
| data_rdata | output | 16 | Data register contents |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO level seen at the pad |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output-enable |

## Verification
The hardware clearing busy at the end of a frame can land in the same clock cycle as a software write to the control register. The bench first confirms the 64 x D duration. It then times a write with the busy bit clear to arrive on exactly that edge. It checks that the write was dropped: busy is clear and the other fields still hold the launch values. A write one cycle later must then be accepted.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_W   = 5;
  localparam int REG_W   = 5;
  localparam int CR_W    = 4;
  localparam int DATA_W  = 16;
  localparam int PRE_LEN = 32;
  localparam int HALF_W  = 7;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;

  // Half of the MDC divisor for a given clock-range code.
  function automatic logic [HALF_W-1:0] half_period(input logic [CR_W-1:0] code);
    logic [HALF_W-1:0] h;
    if (code[CR_W-1]) begin
      h = HALF_W'(code[CR_W-2:0]) + HALF_W'(2);
    end else begin
      case (code[CR_W-2:0])
        3'd1:    h = HALF_W'(31);
        3'd2:    h = HALF_W'(8);
        3'd3:    h = HALF_W'(13);
        3'd4:    h = HALF_W'(51);
        3'd5:    h = HALF_W'(62);
        default: h = HALF_W'(21);
      endcase
    end
    return h;
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int HALF_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              mdc,
  output logic              rise_tick,
  output logic              fall_tick
);
  logic [HALF_W-1:0] cnt_q;
  logic              mdc_q;
  logic              tick;

  assign tick      = run && (cnt_q == half - HALF_W'(1));
  assign rise_tick = tick && !mdc_q;
  assign fall_tick = tick && mdc_q;
  assign mdc       = mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= !mdc_q;
    end else begin
      cnt_q <= cnt_q + HALF_W'(1);
    end
  end

  // R9
  mdc_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc_q) |-> $past(run));
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int PRE_N  = 32,
  parameter int PHY_N  = 5,
  parameter int REG_N  = 5,
  parameter int DATA_N = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_write,
  input  logic [PHY_N-1:0]  phy_addr,
  input  logic [REG_N-1:0]  reg_addr,
  input  logic [DATA_N-1:0] wdata,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              active,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_N-1:0] rdata
);
  localparam int FRAME_LEN = PRE_N + 4 + PHY_N + REG_N + 2 + DATA_N;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int TA_POS    = FRAME_LEN - DATA_N - 2;
  localparam int DATA_POS  = FRAME_LEN - DATA_N;
  localparam int LAST      = FRAME_LEN - 1;

  logic [FRAME_LEN-1:0] frame_q, frame_d;
  logic [IDX_W-1:0]     idx_q;
  logic                 active_q, wr_q, out_q, oe_q;
  logic [DATA_N-1:0]    shreg_q;
  mdio_op_e             op;

  assign op      = is_write ? OP_WRITE : OP_READ;
  assign frame_d = {{PRE_N{1'b1}}, 2'b01, op, phy_addr, reg_addr,
                    (is_write ? 2'b10 : 2'b00),
                    (is_write ? wdata : {DATA_N{1'b0}})};

  assign done    = active_q && fall_tick && (idx_q == IDX_W'(LAST));
  assign active  = active_q;
  assign mdio_o  = out_q;
  assign mdio_oe = oe_q;
  assign rdata   = shreg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q  <= '0;
      idx_q    <= '0;
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      out_q    <= 1'b1;
      oe_q     <= 1'b0;
      shreg_q  <= '0;
    end else if (start && !active_q) begin
      frame_q  <= frame_d;
      idx_q    <= '0;
      active_q <= 1'b1;
      wr_q     <= is_write;
      out_q    <= frame_d[FRAME_LEN-1];
      oe_q     <= 1'b1;
    end else if (active_q) begin
      if (rise_tick && !wr_q && (int'(idx_q) >= DATA_POS))
        shreg_q <= {shreg_q[DATA_N-2:0], mdio_i};
      if (fall_tick) begin
        if (done) begin
          active_q <= 1'b0;
          oe_q     <= 1'b0;
          out_q    <= 1'b1;
        end else begin
          idx_q   <= idx_q + IDX_W'(1);
          frame_q <= frame_q << 1;
          out_q   <= frame_q[FRAME_LEN-2];
          oe_q    <= wr_q || (int'(idx_q) + 1 < TA_POS);
        end
      end
    end
  end

  // R9
  mdio_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q) && !$past(fall_tick)) |-> $stable(out_q));
  // R4
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !wr_q && int'(idx_q) >= TA_POS) |-> !oe_q);
  // R3
  write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && wr_q) |-> oe_q);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int PRE_N  = PRE_LEN,
  parameter int PHY_N  = PHY_W,
  parameter int REG_N  = REG_W,
  parameter int DATA_N = DATA_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ctrl_we,
  input  logic [PHY_N+REG_N+CR_W+1:0]   ctrl_wdata,
  input  logic                          data_we,
  input  logic [DATA_N-1:0]             data_wdata,
  output logic [PHY_N+REG_N+CR_W+1:0]   ctrl_rdata,
  output logic [DATA_N-1:0]             data_rdata,
  output logic                          mdc,
  input  logic                          mdio_i,
  output logic                          mdio_o,
  output logic                          mdio_oe
);
  localparam int BUSY_B = 0;
  localparam int WR_B   = 1;
  localparam int CR_LO  = 2;
  localparam int REG_LO = CR_LO + CR_W;
  localparam int PHY_LO = REG_LO + REG_N;
  localparam int CTRL_N = PHY_LO + PHY_N;

  logic [CTRL_N-1:0] ctrl_q;
  logic [DATA_N-1:0] data_q, rd_word;
  logic              accept, start, done, active, rise_tick, fall_tick;
  logic [HALF_W-1:0] half;

  assign accept     = ctrl_we && !ctrl_q[BUSY_B];
  assign start      = accept && ctrl_wdata[BUSY_B];
  assign half       = half_period(ctrl_q[REG_LO-1:CR_LO]);
  assign ctrl_rdata = ctrl_q;
  assign data_rdata = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
    end else begin
      if (accept)
        ctrl_q <= ctrl_wdata;
      else if (done)
        ctrl_q[BUSY_B] <= 1'b0;
      if (done && !ctrl_q[WR_B])
        data_q <= rd_word;
      else if (data_we)
        data_q <= data_wdata;
    end
  end

  mdio_clkdiv #(.HALF_W(HALF_W)) i_clkdiv (
    .clk(clk), .rst_n(rst_n), .run(active), .half(half),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame #(.PRE_N(PRE_N), .PHY_N(PHY_N), .REG_N(REG_N), .DATA_N(DATA_N)) i_frame (
    .clk(clk), .rst_n(rst_n), .start(start),
    .is_write(ctrl_wdata[WR_B]),
    .phy_addr(ctrl_wdata[CTRL_N-1:PHY_LO]),
    .reg_addr(ctrl_wdata[PHY_LO-1:REG_LO]),
    .wdata(data_q),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .active(active), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(done), .rdata(rd_word)
  );

  // R8
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_q[BUSY_B]) |=> $stable(ctrl_q[CTRL_N-1:WR_B]));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[BUSY_B] |-> (!mdc && !mdio_oe));
  // R10
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[BUSY_B] && ctrl_q[WR_B] && !data_we) |=> $stable(data_q));
endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0, data_we = 1'b0;
  logic [15:0] ctrl_wdata = '0, data_wdata = '0;
  logic [15:0] ctrl_rdata, data_rdata;
  logic        mdc, mdio_i, mdio_o, mdio_oe;

  int checks = 0;
  int failures = 0;

  // PHY stub: records each bit on MDC rise, answers reads from phy_data
  logic [63:0] cap_d = '0, cap_oe = '0;
  int          nrise = 0;
  logic [15:0] phy_data = '0;
  logic        phy_present = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master i_mdio_master (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .data_we(data_we), .data_wdata(data_wdata), .ctrl_rdata(ctrl_rdata),
    .data_rdata(data_rdata), .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe)
  );

  always @(posedge mdc) begin
    cap_d  <= {cap_d[62:0], mdio_o};
    cap_oe <= {cap_oe[62:0], mdio_oe};
    nrise  <= nrise + 1;
  end

  always_comb begin
    int k;
    k = nrise % 64;
    if (phy_present && k >= 48) mdio_i = phy_data[63-k];
    else mdio_i = 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ctrl_write(input logic [15:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic data_write(input logic [15:0] v);
    @(negedge clk); data_we = 1'b1; data_wdata = v;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (ctrl_rdata[0] && cyc < 20000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic run_xact(input logic [15:0] v, output int cyc);
    ctrl_write(v);
    wait_idle(cyc);
  endtask

  function automatic int divisor(input int code);
    case (code)
      0: return 42; 1: return 62; 2: return 16; 3: return 26;
      4: return 102; 5: return 124; 6, 7: return 42;
      default: return 2 * (code - 8) + 4;
    endcase
  endfunction

  function automatic logic [15:0] mk_ctrl(input logic [4:0] phy, input logic [4:0] rg,
                                          input logic [3:0] cr, input logic wr, input logic busy);
    return {phy, rg, cr, wr, busy};
  endfunction

  task automatic t_reset();
    // R1
    chk(ctrl_rdata == 16'h0, "R1 ctrl reset", 64'(ctrl_rdata), 64'h0);
    chk(data_rdata == 16'h0, "R1 data reset", 64'(data_rdata), 64'h0);
    chk(!mdc && !mdio_oe, "R1 lines idle", {62'h0, mdc, mdio_oe}, 64'h0);
  endtask

  task automatic t_write();
    int cyc;
    logic [15:0] v;
    logic [63:0] exp;
    v = mk_ctrl(5'h13, 5'h0A, 4'h8, 1'b1, 1'b1);
    data_write(16'hA5C3);
    run_xact(v, cyc);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h13, 5'h0A, 2'b10, 16'hA5C3};
    chk(cap_d == exp, "R3 write frame bits", cap_d, exp);
    chk(cap_oe == '1, "R3 write drives all bits", cap_oe, '1);
    chk(cyc == 64*4, "R5 write duration code 8", 64'(cyc), 64'(64*4));
    chk(data_rdata == 16'hA5C3, "R10 data kept after write", 64'(data_rdata), 64'hA5C3);
    chk(ctrl_rdata == (v & 16'hFFFE), "R2 ctrl readback", 64'(ctrl_rdata), 64'(v & 16'hFFFE));
    chk(!mdc && !mdio_oe, "R9 idle after write", {62'h0, mdc, mdio_oe}, 64'h0);
  endtask

  task automatic t_read();
    int cyc;
    logic [45:0] exp;
    phy_present = 1'b1;
    phy_data = 16'h3C5A;
    run_xact(mk_ctrl(5'h05, 5'h1F, 4'h9, 1'b0, 1'b1), cyc);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h05, 5'h1F};
    chk(cap_d[63:18] == exp, "R4 read header bits", 64'(cap_d[63:18]), 64'(exp));
    chk(cap_oe == {{46{1'b1}}, 18'h0}, "R4 read release", cap_oe, {{46{1'b1}}, 18'h0});
    chk(data_rdata == 16'h3C5A, "R4 read data", 64'(data_rdata), 64'h3C5A);
    chk(cyc == 64*6, "R5 read duration code 9", 64'(cyc), 64'(64*6));
  endtask

  task automatic t_nophy();
    int cyc;
    phy_present = 1'b0;
    run_xact(mk_ctrl(5'h1F, 5'h01, 4'h2, 1'b0, 1'b1), cyc);
    chk(cyc == 64*16, "R7 no-PHY duration", 64'(cyc), 64'(64*16));
    chk(data_rdata == 16'hFFFF, "R7 no-PHY read value", 64'(data_rdata), 64'hFFFF);
  endtask

  task automatic t_codes();
    for (int c = 0; c < 16; c++) begin
      int cyc;
      run_xact(mk_ctrl(5'h01, 5'h02, 4'(c), 1'b1, 1'b1), cyc);
      if (c == 6 || c == 7)
        chk(cyc == 64*42, "R6 reserved code divisor", 64'(cyc), 64'(64*42));
      else
        chk(cyc == 64*divisor(c), "R5 code divisor", 64'(cyc), 64'(64*divisor(c)));
    end
  endtask

  task automatic t_busy_ignore();
    int cyc;
    logic [15:0] v;
    v = mk_ctrl(5'h0C, 5'h03, 4'hA, 1'b1, 1'b1);
    ctrl_write(v);
    repeat (10) @(negedge clk);
    ctrl_write(mk_ctrl(5'h1E, 5'h1D, 4'h3, 1'b0, 1'b0));
    chk(ctrl_rdata == v, "R8 write during busy ignored", 64'(ctrl_rdata), 64'(v));
    wait_idle(cyc);
    chk(ctrl_rdata == (v & 16'hFFFE), "R8 fields kept to end", 64'(ctrl_rdata), 64'(v & 16'hFFFE));
  endtask

  task automatic t_collide();
    logic [15:0] v1, v2;
    v1 = mk_ctrl(5'h07, 5'h11, 4'h8, 1'b1, 1'b1);
    v2 = mk_ctrl(5'h19, 5'h06, 4'h3, 1'b0, 1'b0);
    ctrl_write(v1);
    repeat (64*4 - 1) @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = v2;
    @(negedge clk); ctrl_we = 1'b0;
    chk(ctrl_rdata == (v1 & 16'hFFFE), "R8 write on completion edge ignored",
        64'(ctrl_rdata), 64'(v1 & 16'hFFFE));
    ctrl_write(v2);
    chk(ctrl_rdata == v2, "R8 next write accepted", 64'(ctrl_rdata), 64'(v2));
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_nophy();
    t_codes();
    t_busy_ignore();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule